// File: doc/BRIEF.md
# Flow Control Nibble Serial Port

This block takes the first header octet of each received ATM cell and keeps only its upper four bits, the generic flow control field. It sends those four bits out on a one-wire serial line, together with a port clock and a marker line. Nibbles from successive cells follow one another without a gap. The marker is high for the whole of each nibble's first bit, so a downstream receiver can find nibble boundaries without any cell boundary signal.

The cell receiver offers a header octet with `hdr_valid` and flags the first octet of a cell with `cell_start`. A nibble is taken on every clock where both are high. The block has one holding slot for a nibble that waits behind the one being shifted out, and `hdr_ready` reports whether that slot is free. Back-pressure is advisory. If a sender offers a new first octet while `hdr_ready` is low, the held nibble is replaced by the newer one and the sticky `overflow` flag is set. The port clock runs at a quarter of the system clock. It runs only while a nibble is being sent and otherwise stays low.

Top module: `gfc_serial_out`

## Requirements
- R1: A nibble is captured from bits 7:4 of `hdr_octet` only on a clock where `cell_start` and `hdr_valid` are both high. `cell_start` without `hdr_valid`, or `hdr_valid` without `cell_start`, produces no serial output.
- R2: Each nibble is sent bit 3 first, then bits 2, 1 and 0. Every bit stays on `ser_data` for four system clocks.
- R3: When a nibble is waiting at the moment the current nibble's bit 0 period ends, the waiting nibble's bit 3 starts on the very next system clock, with no idle period in between.
- R4: Within each four-clock bit period, `ser_clk` is low for the first two clocks and high for the last two. `ser_data` and `ser_msb` change only when a bit period starts, so they are stable at every rising edge of `ser_clk`.
- R5: `ser_msb` is high for exactly the four clocks of each nibble's bit 3 period and is low at all other times.
- R6: While no nibble is being sent, `ser_clk`, `ser_data` and `ser_msb` are all low.
- R7: The holding slot keeps one nibble. `hdr_ready` is high exactly when the slot is empty. A capture while the slot is full and the slot is not being drained on the same clock replaces the held nibble and sets `overflow`, which then stays high until reset.
- R8: A synchronous active-high `rst` empties the holding slot, stops the shifter and clears `overflow`. The clock after `rst` shows `ser_clk`, `ser_data`, `ser_msb` and `overflow` low and `hdr_ready` high.
- R9: When the block is idle, a capture at clock edge k puts that nibble's bit 3 and the marker on the outputs after clock edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cell_start | input | 1 | Marks the offered octet as a cell's first header octet |
| hdr_valid | input | 1 | Offered octet is valid |
| hdr_ready | output | 1 | Holding slot is empty (advisory) |
| hdr_octet | input | 8 | Header octet; bits 7:4 are the flow control nibble |
| ser_data | output | 1 | Serial nibble data |
| ser_clk | output | 1 | Port clock, system clock divided by four, gated |
| ser_msb | output | 1 | High during each nibble's first bit |
| overflow | output | 1 | Sticky flag: a held nibble was overwritten |

## Verification
The assertions check several rules on every clock. The lines stay quiet while the shifter is idle. Data and marker are stable at each port-clock rise, and the marker never begins while the port clock is high. The slot drains only when it is full, and the overflow flag stays set once it is set. A full slot that is written and not drained ends with the newer nibble and the flag set. A queued nibble follows bit 0 without a gap. The bench's scenarios are what show the values themselves: the bit order of chosen nibbles, that half-formed strobes are ignored, the latency from capture to first bit, which nibble is kept after an overwrite, and recovery from a reset in the middle of a nibble.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
  localparam int GFC_NIB_W = 4;
  localparam int GFC_OCT_W = 8;
  localparam int GFC_DIV   = 4;
endpackage

// File: rtl/gfc_hold_slot.sv
module gfc_hold_slot #(
  parameter int NIB_W = gfc_pkg::GFC_NIB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_vld,
  input  logic [NIB_W-1:0] cap_nib,
  input  logic             take,
  output logic             full,
  output logic [NIB_W-1:0] nib,
  output logic             ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      nib  <= '0;
      ovf  <= 1'b0;
    end else if (cap_vld) begin
      nib  <= cap_nib;
      full <= 1'b1;
      if (full && !take) ovf <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  a_r7_drain_needs_full: assert property (@(posedge clk) disable iff (rst)
    take |-> full);
  a_r7_overwrite_newest: assert property (@(posedge clk) disable iff (rst)
    (full && cap_vld && !take) |=> (ovf && full && nib == $past(cap_nib)));
endmodule

// File: rtl/gfc_bit_timer.sv
module gfc_bit_timer #(
  parameter int DIV = gfc_pkg::GFC_DIV
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic bit_end,
  output logic pclk
);
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam logic [PW-1:0] LAST_P = PW'(DIV - 1);
  localparam logic [PW-1:0] HALF_P = PW'(HALF);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || !run)        phase <= '0;
    else if (phase == LAST_P) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign bit_end = run && (phase == LAST_P);
  assign pclk    = run && (phase >= HALF_P);

  a_r4_rise_at_half: assert property (@(posedge clk) disable iff (rst)
    $rose(pclk) |-> (phase == HALF_P));
endmodule

// File: rtl/gfc_nib_shifter.sv
module gfc_nib_shifter #(
  parameter int NIB_W = gfc_pkg::GFC_NIB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_full,
  input  logic [NIB_W-1:0] hold_nib,
  input  logic             bit_end,
  output logic             take,
  output logic             busy,
  output logic             sdata,
  output logic             smsb
);
  localparam int CW = (NIB_W > 2) ? $clog2(NIB_W) : 1;
  localparam logic [CW-1:0] LAST_B = CW'(NIB_W - 1);

  logic [NIB_W-1:0] sh;
  logic [CW-1:0]    cnt;
  logic             last_bit;

  assign last_bit = (cnt == LAST_B);
  assign take     = hold_full && (!busy || (bit_end && last_bit));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sh   <= '0;
      cnt  <= '0;
    end else if (take) begin
      busy <= 1'b1;
      sh   <= hold_nib;
      cnt  <= '0;
    end else if (busy && bit_end) begin
      if (last_bit) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        sh  <= {sh[NIB_W-2:0], 1'b0};
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign sdata = busy && sh[NIB_W-1];
  assign smsb  = busy && (cnt == '0);

  a_r3_no_gap: assert property (@(posedge clk) disable iff (rst)
    (busy && bit_end && last_bit && hold_full) |=> (busy && smsb));
  a_r5_marker_ends: assert property (@(posedge clk) disable iff (rst)
    (smsb && bit_end && !take) |=> !smsb);
endmodule

// File: rtl/gfc_serial_out.sv
module gfc_serial_out #(
  parameter int NIB_W = gfc_pkg::GFC_NIB_W,
  parameter int OCT_W = gfc_pkg::GFC_OCT_W,
  parameter int DIV   = gfc_pkg::GFC_DIV
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cell_start,
  input  logic             hdr_valid,
  output logic             hdr_ready,
  input  logic [OCT_W-1:0] hdr_octet,
  output logic             ser_data,
  output logic             ser_clk,
  output logic             ser_msb,
  output logic             overflow
);
  logic             cap_vld;
  logic [NIB_W-1:0] cap_nib;
  logic             take, busy, bit_end, full;
  logic [NIB_W-1:0] held;

  assign cap_vld   = cell_start && hdr_valid;
  assign cap_nib   = hdr_octet[OCT_W-1 -: NIB_W];
  assign hdr_ready = !full;

  gfc_hold_slot #(.NIB_W(NIB_W)) u_slot (
    .clk(clk), .rst(rst), .cap_vld(cap_vld), .cap_nib(cap_nib),
    .take(take), .full(full), .nib(held), .ovf(overflow)
  );

  gfc_bit_timer #(.DIV(DIV)) u_timer (
    .clk(clk), .rst(rst), .run(busy), .bit_end(bit_end), .pclk(ser_clk)
  );

  gfc_nib_shifter #(.NIB_W(NIB_W)) u_shift (
    .clk(clk), .rst(rst), .hold_full(full), .hold_nib(held),
    .bit_end(bit_end), .take(take), .busy(busy),
    .sdata(ser_data), .smsb(ser_msb)
  );

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ser_clk && !ser_data && !ser_msb));
  a_r4_stable_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> ($stable(ser_data) && $stable(ser_msb)));
  a_r5_marker_starts_low: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_msb) |-> !ser_clk);
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!ser_clk && !ser_data && !ser_msb && !overflow && hdr_ready));
endmodule

// File: tb/test_gfc_serial_out.sv
module test_gfc_serial_out;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cell_start = 1'b0;
  logic       hdr_valid = 1'b0;
  logic [7:0] hdr_octet = 8'h00;
  logic       hdr_ready, ser_data, ser_clk, ser_msb, overflow;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit go     = 1'b0;
  string scen = "R8";

  always #(CLK_PERIOD/2) clk = ~clk;

  gfc_serial_out i_gfc_serial_out (
    .clk(clk), .rst(rst), .cell_start(cell_start), .hdr_valid(hdr_valid),
    .hdr_ready(hdr_ready), .hdr_octet(hdr_octet), .ser_data(ser_data),
    .ser_clk(ser_clk), .ser_msb(ser_msb), .overflow(overflow)
  );

  // behavioural reference: pending queue (max one) and a cycle index within the nibble
  bit [3:0] pend[$];
  bit       m_act = 0;
  int       m_t   = 0;
  bit [3:0] m_cur = 0;
  bit       m_ovf = 0;

  always @(posedge clk) begin
    if (rst) begin
      pend.delete(); m_act = 0; m_t = 0; m_cur = 0; m_ovf = 0;
    end else begin
      bit had;
      had = (pend.size() > 0);
      if (m_act) begin
        if (m_t == 15) begin
          if (had) begin m_cur = pend.pop_front(); m_t = 0; end
          else begin m_act = 0; m_t = 0; end
        end else m_t++;
      end else if (had) begin
        m_cur = pend.pop_front(); m_act = 1; m_t = 0;
      end
      if (cell_start && hdr_valid) begin
        if (pend.size() == 1) begin m_ovf = 1; pend.delete(); end
        pend.push_back(hdr_octet[7:4]);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] at cycle %0d: actual %b expected %b", req, scen, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (go) begin
      chk("R2 data", ser_data, m_act ? m_cur[3 - m_t/4] : 1'b0);
      chk("R4 clk",  ser_clk,  m_act && ((m_t % 4) >= 2));
      chk("R5 msb",  ser_msb,  m_act && (m_t < 4));
      chk("R7 ready", hdr_ready, pend.size() == 0);
      chk("R7 ovf",  overflow, m_ovf);
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic offer(input logic s, input logic v, input logic [7:0] o);
    cell_start = s; hdr_valid = v; hdr_octet = o;
    @(negedge clk);
    cell_start = 0; hdr_valid = 0; hdr_octet = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 0;
    // R8: state after reset
    chk("R8 clk", ser_clk, 1'b0);
    chk("R8 data", ser_data, 1'b0);
    chk("R8 ovf", overflow, 1'b0);
    chk("R8 ready", hdr_ready, 1'b1);
    go = 1;

    scen = "R9";
    offer(1, 1, 8'hA5);
    @(negedge clk);
    chk("R9 msb latency", ser_msb, 1'b1);
    chk("R9 first bit", ser_data, 1'b1);
    idle(20);

    scen = "R1";
    offer(1, 0, 8'hF0);
    offer(0, 1, 8'hF0);
    idle(2);
    chk("R1 ignored strobe", ser_clk, 1'b0);
    idle(18);

    scen = "R2";
    offer(1, 1, 8'h3C); idle(20);
    offer(1, 1, 8'hF0); idle(20);
    offer(1, 1, 8'h0F); idle(20);

    scen = "R3";
    offer(1, 1, 8'h90); idle(2);
    offer(1, 1, 8'h60); idle(40);

    scen = "R7";
    offer(1, 1, 8'h10);
    offer(1, 1, 8'h20);
    offer(1, 1, 8'h30);
    offer(1, 1, 8'h40);
    chk("R7 overflow set", overflow, 1'b1);
    idle(60);
    chk("R7 overflow sticky", overflow, 1'b1);

    scen = "R8";
    offer(1, 1, 8'hC0); idle(6);
    rst = 1; idle(2); rst = 0;
    chk("R8 mid reset clk", ser_clk, 1'b0);
    chk("R8 mid reset ovf", overflow, 1'b0);
    chk("R8 mid reset ready", hdr_ready, 1'b1);
    scen = "R6";
    idle(10);
    offer(1, 1, 8'h50); idle(24);
    finish_run();
  end
endmodule